// File: doc/BRIEF.md
# Four-Point Convolution and Correlation Unit

The unit takes two sets of four unsigned 4-bit samples, `g` and `h`. Each time the input strobe fires, it produces seven output points in one of three ways: the linear convolution of `g` with `h`, the cross-correlation of `g` with `h`, or the auto-correlation of `g`. All three share one direct-method datapath. Every product pair is formed in parallel, and each output point is the sum of the products whose sample indices add up to that point's index.

Correlation comes from reversing the sample order of the second operand before it enters the shared datapath. In auto mode, `g` feeds both operands and the second copy is reversed, so the `h` port plays no part. The mode is captured on the same clock edge as the data, and the result appears one clock later.

Top module: `corr_unit`

## Requirements
- R1: With mode code 2'b00, output point n (n = 0..6) is the sum over i of g[i]*h[n-i], taking only indices inside 0..3. Sample k of an input sits at bits [4k+3:4k], and point n sits at bits [10n+9:10n] of `lags_o`.
- R2: With mode code 2'b01, the output is the convolution of g with h reversed (second operand sample k = h[3-k]). For g = h = (1,2,3,4) this gives 4, 11, 20, 30, 20, 11, 4.
- R3: With mode code 2'b10, the output is the convolution of g with g reversed. The value on `h_i` has no effect on the result.
- R4: Mode code 2'b11 gives the same result as mode code 2'b00.
- R5: `valid_o` is high in exactly the cycles that follow a cycle with `valid_i` high. The result captured with that strobe is on `lags_o` at the same time. After reset, `valid_o` is 0 and every point is 0.
- R6: While `valid_i` is low, `lags_o` holds its last value, whatever `g_i`, `h_i` and `mode_i` do. A mode change therefore affects only later strobes.
- R7: No output point overflows. With every sample at 15, convolution gives 225, 450, 675, 900, 675, 450, 225.
- R8: An auto-correlation result is symmetric: point n equals point 6-n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Captures samples and mode on this edge |
| mode_i | input | 2 | 00 convolution, 01 cross-correlation, 10 auto-correlation, 11 convolution |
| g_i | input | 16 | First sequence, four 4-bit samples, sample 0 in the low bits |
| h_i | input | 16 | Second sequence, same layout; unused in auto mode |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| lags_o | output | 70 | Seven 10-bit output points, point 0 in the low bits |

## Verification
The checks on the output hold and the valid pairing assume that `valid_i` is a clean single-bit level. They also assume that `g_i`, `h_i` and `mode_i` are stable around the capturing edge. The bench meets this by changing every input only on the falling clock edge.

The symmetry and range checks rely on the samples being unsigned 4-bit values. Random stimulus draws from the full 0..15 range, so the all-15 extreme and the zero sample are covered as well as directed vectors. Random strobes are mixed with idle cycles in which the data and mode move without `valid_i`, so that the hold behaviour is exercised while the inputs are changing.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int unsigned SAMP_W = 4;
  localparam int unsigned NPTS   = 4;
  localparam int unsigned PROD_W = 2 * SAMP_W;
  localparam int unsigned NLAGS  = 2 * NPTS - 1;
  localparam int unsigned OUT_W  = PROD_W + $clog2(NPTS);

  typedef enum logic [1:0] {
    MODE_CONV  = 2'b00,
    MODE_XCORR = 2'b01,
    MODE_ACORR = 2'b10,
    MODE_ALT   = 2'b11
  } corr_mode_e;
endpackage

// File: rtl/corr_operand_sel.sv
module corr_operand_sel
  import corr_pkg::*;
#(
  parameter int unsigned W = SAMP_W,
  parameter int unsigned N = NPTS
) (
  input  logic [1:0]     mode_i,
  input  logic [N*W-1:0] g_i,
  input  logic [N*W-1:0] h_i,
  output logic [N*W-1:0] a_o,
  output logic [N*W-1:0] b_o
);
  assign a_o = g_i;

  for (genvar k = 0; k < N; k++) begin : g_sel
    localparam int unsigned RK = N - 1 - k;
    always_comb begin
      unique case (mode_i)
        MODE_XCORR: b_o[k*W +: W] = h_i[RK*W +: W];
        MODE_ACORR: b_o[k*W +: W] = g_i[RK*W +: W];
        default:    b_o[k*W +: W] = h_i[k*W +: W];
      endcase
    end
  end
endmodule

// File: rtl/corr_conv_core.sv
module corr_conv_core
  import corr_pkg::*;
#(
  parameter int unsigned W = SAMP_W,
  parameter int unsigned N = NPTS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [N*W-1:0]        a_i,
  input  logic [N*W-1:0]        b_i,
  output logic                  valid_o,
  output logic [(2*N-1)*(2*W+$clog2(N))-1:0] lags_o
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned OW = PW + $clog2(N);
  localparam int unsigned NL = 2 * N - 1;

  logic [PW-1:0]      prod [N][N];
  logic [NL*OW-1:0]   sum_d;
  logic [NL*OW-1:0]   sum_q;
  logic               vld_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign prod[i][j] = PW'(a_i[i*W +: W]) * PW'(b_i[j*W +: W]);
    end
  end

  // point n collects every product whose index pair sums to n
  for (genvar n = 0; n < NL; n++) begin : g_lag
    always_comb begin
      logic [OW-1:0] acc;
      acc = '0;
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (i + j == n) acc = acc + OW'(prod[i][j]);
        end
      end
      sum_d[n*OW +: OW] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      sum_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) sum_q <= sum_d;
    end
  end

  assign valid_o = vld_q;
  assign lags_o  = sum_q;
endmodule

// File: rtl/corr_unit.sv
module corr_unit
  import corr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [1:0]             mode_i,
  input  logic [NPTS*SAMP_W-1:0] g_i,
  input  logic [NPTS*SAMP_W-1:0] h_i,
  output logic                   valid_o,
  output logic [NLAGS*OUT_W-1:0] lags_o
);
  logic [NPTS*SAMP_W-1:0] op_a;
  logic [NPTS*SAMP_W-1:0] op_b;

  corr_operand_sel #(.W(SAMP_W), .N(NPTS)) u_sel (
    .mode_i (mode_i),
    .g_i    (g_i),
    .h_i    (h_i),
    .a_o    (op_a),
    .b_o    (op_b)
  );

  corr_conv_core #(.W(SAMP_W), .N(NPTS)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (op_a),
    .b_i     (op_b),
    .valid_o (valid_o),
    .lags_o  (lags_o)
  );
endmodule

// File: rtl/corr_unit_chk.sv
module corr_unit_chk
  import corr_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [1:0]             mode_i,
  input logic                   valid_o,
  input logic [NLAGS*OUT_W-1:0] lags_o
);
  logic sym_ok;
  logic bound_ok;

  always_comb begin
    sym_ok   = 1'b1;
    bound_ok = 1'b1;
    for (int n = 0; n < int'(NLAGS); n++) begin
      int unsigned terms;
      terms = (n < int'(NPTS)) ? n + 1 : NLAGS - n;
      if (lags_o[n*OUT_W +: OUT_W] != lags_o[(NLAGS-1-n)*OUT_W +: OUT_W]) sym_ok = 1'b0;
      if (int'(lags_o[n*OUT_W +: OUT_W]) > int'(terms) * ((1 << SAMP_W) - 1) * ((1 << SAMP_W) - 1))
        bound_ok = 1'b0;
    end
  end

  // R5
  valid_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R5
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(lags_o));

  // R8
  auto_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_ACORR) |=> sym_ok);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_ok);
endmodule

bind corr_unit corr_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .mode_i  (mode_i),
  .valid_o (valid_o),
  .lags_o  (lags_o)
);

// File: tb/corr_unit_tb.sv
module corr_unit_tb;
  import corr_pkg::*;

  localparam int unsigned GW = NPTS * SAMP_W;
  localparam int unsigned LW = NLAGS * OUT_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [GW-1:0] g_i = '0;
  logic [GW-1:0] h_i = '0;
  logic          valid_o;
  logic [LW-1:0] lags_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  corr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .g_i(g_i), .h_i(h_i), .valid_o(valid_o), .lags_o(lags_o)
  );

  function automatic logic [GW-1:0] pack4(int s0, int s1, int s2, int s3);
    return {SAMP_W'(s3), SAMP_W'(s2), SAMP_W'(s1), SAMP_W'(s0)};
  endfunction

  function automatic logic [LW-1:0] pack7(int y0, int y1, int y2, int y3, int y4, int y5, int y6);
    return {OUT_W'(y6), OUT_W'(y5), OUT_W'(y4), OUT_W'(y3), OUT_W'(y2), OUT_W'(y1), OUT_W'(y0)};
  endfunction

  function automatic logic [LW-1:0] ref_model(logic [GW-1:0] g, logic [GW-1:0] h, logic [1:0] m);
    logic [LW-1:0] r;
    int a [NPTS];
    int b [NPTS];
    r = '0;
    for (int k = 0; k < int'(NPTS); k++) begin
      a[k] = int'(g[k*SAMP_W +: SAMP_W]);
      if (m == 2'b01)      b[k] = int'(h[(NPTS-1-k)*SAMP_W +: SAMP_W]);
      else if (m == 2'b10) b[k] = int'(g[(NPTS-1-k)*SAMP_W +: SAMP_W]);
      else                 b[k] = int'(h[k*SAMP_W +: SAMP_W]);
    end
    for (int n = 0; n < int'(NLAGS); n++) begin
      int s;
      s = 0;
      for (int i = 0; i < int'(NPTS); i++)
        if (n - i >= 0 && n - i < int'(NPTS)) s += a[i] * b[n-i];
      r[n*OUT_W +: OUT_W] = OUT_W'(s);
    end
    return r;
  endfunction

  task automatic check(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, capture at next rising edge, sample at following falling edge
  task automatic strobe(string req, logic [GW-1:0] g, logic [GW-1:0] h, logic [1:0] m,
                        logic [LW-1:0] exp);
    g_i = g; h_i = h; mode_i = m; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, lags_o, exp);
    check({req, "_R5_valid"}, LW'(valid_o), LW'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [LW-1:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R5_reset_lags", lags_o, '0);
    check("R5_reset_valid", LW'(valid_o), LW'(0));
    rst_n = 1'b1;
    @(negedge clk);

    strobe("R1", pack4(1,2,3,4), pack4(1,2,3,4), 2'b00, pack7(1,4,10,20,25,24,16));
    strobe("R2", pack4(1,2,3,4), pack4(1,2,3,4), 2'b01, pack7(4,11,20,30,20,11,4));
    strobe("R3", pack4(1,2,3,4), pack4(9,7,5,15), 2'b10, pack7(4,11,20,30,20,11,4));
    strobe("R3_h_ignored", pack4(1,2,3,4), pack4(0,0,0,0), 2'b10, pack7(4,11,20,30,20,11,4));
    strobe("R4", pack4(2,0,5,1), pack4(3,4,0,7), 2'b11, ref_model(pack4(2,0,5,1), pack4(3,4,0,7), 2'b00));
    strobe("R7", pack4(15,15,15,15), pack4(15,15,15,15), 2'b00, pack7(225,450,675,900,675,450,225));
    strobe("R7_auto", pack4(15,15,15,15), '0, 2'b10, pack7(225,450,675,900,675,450,225));

    // R6: inputs move without strobe
    held = lags_o;
    g_i = pack4(3,3,3,3); h_i = pack4(1,1,1,1); mode_i = 2'b01;
    @(negedge clk);
    check("R6_hold", lags_o, held);
    check("R6_valid_low", LW'(valid_o), LW'(0));
    mode_i = 2'b10;
    @(negedge clk);
    check("R6_mode_change", lags_o, held);

    for (int t = 0; t < 300; t++) begin
      logic [GW-1:0] g;
      logic [GW-1:0] h;
      logic [1:0]    m;
      logic [LW-1:0] e;
      g = GW'($urandom);
      h = GW'($urandom);
      m = 2'($urandom);
      e = ref_model(g, h, m);
      case (m)
        2'b00:   strobe("R1_rand", g, h, m, e);
        2'b01:   strobe("R2_rand", g, h, m, e);
        2'b10:   strobe("R3_rand", g, h, m, e);
        default: strobe("R4_rand", g, h, m, e);
      endcase
      if (m == 2'b10) begin
        for (int n = 0; n < int'(NLAGS); n++)
          check("R8_sym", LW'(lags_o[n*OUT_W +: OUT_W]), LW'(lags_o[(NLAGS-1-n)*OUT_W +: OUT_W]));
      end
      if (($urandom % 3) == 0) begin
        held = lags_o;
        g_i = GW'($urandom); h_i = GW'($urandom); mode_i = 2'($urandom);
        @(negedge clk);
        check("R6_rand_hold", lags_o, held);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule